// File: doc/BRIEF.md
# Edge-Triggered Interrupt Request Controller

This block gathers interrupt requests from eight input lines and presents the most urgent one to a processor. A request opens when its line goes from low to high. It is then held in a pending register for as long as the line stays high. A mask register can hide pending requests from the processor, and an in-service register records which requests the processor has taken and not yet finished.

The processor sees a single request output. It answers with a one-cycle acknowledge pulse. One cycle later the block returns an 8-bit vector, made of a programmable 5-bit base followed by the 3-bit line number. If the request that caused the output has gone away by the time of the acknowledge, because its line fell or was masked, the block returns the lowest-priority vector and records nothing as in service. A small write port sets the mask and the vector base, and issues a nonspecific end-of-interrupt command.

Top module: `irq_ctrl`

## Requirements
- R1: A pending bit is set only when its line is sampled high one clock after it was sampled low. A line that is already high when reset is released raises no request until it falls and rises again.
- R2: While a request is pending, its pending bit clears on the clock edge at which its line is sampled low. A request withdrawn this way is never delivered.
- R3: After a line is acknowledged, it raises no new request while it stays high. Only a fresh low-to-high transition raises one.
- R4: Priority is fixed: line 0 is highest and line 7 is lowest. `int_req_o` is high exactly when some pending, unmasked line has higher priority than the highest-priority in-service line, or when some pending, unmasked line exists and nothing is in service.
- R5: When `int_ack_i` is high at a clock edge, the highest-priority eligible line (as defined in R4) moves from pending to in service. In the next cycle `vec_valid_o` is high for one cycle and `vec_o` = {base[4:0], line[2:0]}.
- R6: When `int_ack_i` is high at a clock edge and no line is eligible, `vec_o` = {base, 3'b111} is returned the next cycle and the in-service register is left unchanged.
- R7: Masking a line does not clear its pending bit. Once the line is unmasked while still high, it requests again.
- R8: An end-of-interrupt command clears only the highest-priority in-service bit.
- R9: Writes occur when `cfg_we_i` is high at a clock edge. `cfg_sel_i`=0 loads the mask from `cfg_data_i` (bit n = 1 masks line n). `cfg_sel_i`=1 loads the base from `cfg_data_i[4:0]`. `cfg_sel_i`=2 issues end-of-interrupt. Reset clears the mask, base, pending and in-service registers and `vec_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 8 | Interrupt request lines |
| cfg_we_i | input | 1 | Write strobe of the configuration port |
| cfg_sel_i | input | 2 | Write target: 0 mask, 1 base, 2 end-of-interrupt |
| cfg_data_i | input | 8 | Write data |
| int_req_o | output | 1 | Request to the processor |
| int_ack_i | input | 1 | Acknowledge pulse from the processor |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Returned vector |

## Verification
A vector table drives single-line, multi-line, partly masked and fully masked request patterns, each with a different base. This separates the priority choice, the mask filter and the construction of the vector. Directed cases cover the following:
- a line held high through reset, which tells edge detection apart from level detection;
- a line that drops before acknowledge, and a line that is masked after being signalled, which separate a withdrawn request from a phantom delivery;
- a line kept high after it is serviced;
- nested requests, where end-of-interrupt must uncover a blocked lower-priority line only after the correct in-service bit clears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned VEC_W  = 8;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_BASE = 2'd1,
    SEL_EOI  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irqc_edge_capture.sv
module irqc_edge_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    // The delayed copy resets high, so a line already high at reset
    // release does not count as an edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b1;
      else        prev_q[g] <= line_i[g];
    end
    assign rise_o[g] = line_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] irr_q;

  // Set on a rising edge, held while the line stays high, dropped on
  // withdrawal or when taken into service.
  function automatic logic [N-1:0] next_pending(
    input logic [N-1:0] cur, input logic [N-1:0] rise,
    input logic [N-1:0] lvl, input logic [N-1:0] take);
    return ((cur | rise) & lvl) & ~take;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irr_q <= '0;
    else        irr_q <= next_pending(irr_q, rise_i, line_i, take_i);
  end

  assign irr_o = irr_q;

  // R1: a pending bit appears only after an edge was seen
  p_set_needs_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & ~$past(irr_q) & ~$past(rise_i)) == '0));
  // R2: a pending bit never outlives a low sample of its line
  p_withdraw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & ~$past(line_i)) == '0));
  // R3: a taken line is not pending right after
  p_taken_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & $past(take_i)) == '0));
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  imr_i,
  input  logic [N-1:0]  isr_i,
  output logic [N-1:0]  cand_o,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] grant_idx_o,
  output logic          grant_any_o
);
  // Lines strictly more urgent than the most urgent in-service line.
  function automatic logic [N-1:0] prio_window(input logic [N-1:0] isr);
    logic [N-1:0] win;
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      seen   = seen | isr[i];
      win[i] = ~seen;
    end
    return win;
  endfunction

  function automatic logic [N-1:0] lowest_onehot(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [IW-1:0] onehot_index(input logic [N-1:0] oh);
    logic [IW-1:0] idx;
    idx = '0;
    for (int i = 0; i < N; i++)
      if (oh[i]) idx = IW'(i);
    return idx;
  endfunction

  always_comb begin
    cand_o      = irr_i & ~imr_i & prio_window(isr_i);
    grant_o     = lowest_onehot(cand_o);
    grant_idx_o = onehot_index(grant_o);
    grant_any_o = |cand_o;
  end

  // R4: the grant is a single line that is pending and not masked
  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && ((grant_o & ~irr_i) == '0) && ((grant_o & imr_i) == '0));
endmodule

// File: rtl/irqc_in_service.sv
module irqc_in_service #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         eoi_i,
  output logic [N-1:0] isr_o
);
  logic [N-1:0] isr_q;
  logic [N-1:0] eoi_clr;

  function automatic logic [N-1:0] top_bit(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  assign eoi_clr = eoi_i ? top_bit(isr_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~eoi_clr) | set_i;
  end

  assign isr_o = isr_q;

  // R8: end-of-interrupt alone removes exactly one in-service bit
  p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && (set_i == '0) && (isr_q != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
  // R5: a granted line is in service on the next cycle
  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((isr_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N      = LINES,
  parameter int unsigned VW     = VEC_W,
  localparam int unsigned IW    = $clog2(N),
  localparam int unsigned BW    = VW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_lines_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [N-1:0]  cfg_data_i,
  output logic          int_req_o,
  input  logic          int_ack_i,
  output logic          vec_valid_o,
  output logic [VW-1:0] vec_o
);
  localparam logic [IW-1:0] SPURIOUS_IDX = IW'(N - 1);

  logic [N-1:0]  rise, irr, isr, cand, grant, take;
  logic [N-1:0]  imr_q;
  logic [BW-1:0] base_q;
  logic [IW-1:0] grant_idx;
  logic          grant_any, eoi;
  cfg_sel_e      sel;

  assign sel  = cfg_sel_e'(cfg_sel_i);
  assign eoi  = cfg_we_i && (sel == SEL_EOI);
  assign take = int_ack_i ? grant : '0;

  irqc_edge_capture #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_i(irq_lines_i), .rise_o(rise));

  irqc_pending #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .line_i(irq_lines_i), .rise_i(rise),
    .take_i(take), .irr_o(irr));

  irqc_resolver #(.N(N), .IW(IW)) u_res (
    .clk(clk), .rst_n(rst_n), .irr_i(irr), .imr_i(imr_q), .isr_i(isr),
    .cand_o(cand), .grant_o(grant), .grant_idx_o(grant_idx),
    .grant_any_o(grant_any));

  irqc_in_service #(.N(N)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_i(take), .eoi_i(eoi), .isr_o(isr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q  <= '0;
      base_q <= '0;
    end else if (cfg_we_i) begin
      if (sel == SEL_MASK) imr_q  <= cfg_data_i;
      if (sel == SEL_BASE) base_q <= cfg_data_i[BW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      vec_valid_o <= int_ack_i;
      if (int_ack_i)
        vec_o <= {base_q, grant_any ? grant_idx : SPURIOUS_IDX};
    end
  end

  assign int_req_o = |cand;

  // R6: an acknowledge with nothing eligible returns the lowest line's code
  p_spurious_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack_i && !grant_any) |=> (vec_valid_o && (vec_o[IW-1:0] == SPURIOUS_IDX)));
  // R5: the vector is valid exactly one cycle after each acknowledge
  p_vec_follows_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(int_ack_i));
  // R4: an in-service line never requests again while still in service
  p_no_self_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cand & isr) == '0));
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lines = '0;
  logic       we = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] data = '0;
  logic       ack = 1'b0;
  logic       int_req, vvalid;
  logic [7:0] vec;
  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .cfg_we_i(we),
    .cfg_sel_i(sel), .cfg_data_i(data), .int_req_o(int_req),
    .int_ack_i(ack), .vec_valid_o(vvalid), .vec_o(vec));

  // {mask[20:13], pattern[12:5], base[4:0]}
  localparam logic [20:0] TABLE [6] = '{
    {8'h00, 8'b0000_0001, 5'h04},
    {8'h00, 8'b1000_0000, 5'h1F},
    {8'h00, 8'b0101_0100, 5'h02},
    {8'h04, 8'b0101_0100, 5'h02},
    {8'hFF, 8'b0011_0000, 5'h09},
    {8'h0F, 8'b1100_0011, 5'h10}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic cfg(input logic [1:0] s, input logic [7:0] d);
    we = 1'b1; sel = s; data = d; tick(); we = 1'b0;
  endtask

  task automatic do_ack(); ack = 1'b1; tick(); ack = 1'b0; endtask

  // Independent model: first set bit scanning from line 0
  function automatic int first_line(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    lines = 8'h08;                        // line 3 held high through reset
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    check("R9 reset int_req", {7'b0, int_req}, 8'h00);
    check("R9 reset vec_valid", {7'b0, vvalid}, 8'h00);
    check("R1 high-at-reset no request", {7'b0, int_req}, 8'h00);
    lines = 8'h00; tick();
    lines = 8'h08; tick();
    check("R1 fresh edge requests", {7'b0, int_req}, 8'h01);
    do_ack();
    check("R5 vector line3 base0", vec, 8'h03);
    check("R5 valid after ack", {7'b0, vvalid}, 8'h01);
    tick();
    check("R5 valid one cycle", {7'b0, vvalid}, 8'h00);
    cfg(2'd2, 8'h00);
    tick(); tick();
    check("R3 held line no re-request", {7'b0, int_req}, 8'h00);
    lines = 8'h00; tick();

    // Table walk: R4 priority, R9 mask/base, R5/R6 vectors
    foreach (TABLE[k]) begin
      logic [7:0] m, p;
      logic [4:0] b;
      int ln;
      {m, p, b} = TABLE[k];
      ln = first_line(p & ~m);
      cfg(2'd0, m);
      cfg(2'd1, {3'b0, b});
      lines = p; tick();
      check($sformatf("R4 table %0d int_req", k), {7'b0, int_req}, (ln >= 0) ? 8'h01 : 8'h00);
      do_ack();
      check($sformatf("R5/R6 table %0d vector", k), vec,
            {b, (ln >= 0) ? 3'(ln) : 3'd7});
      if (ln >= 0) cfg(2'd2, 8'h00);
      lines = 8'h00; tick();
    end
    cfg(2'd0, 8'h00);
    cfg(2'd1, 8'h00);

    // R2 withdrawal then spurious; R6 in-service untouched
    lines = 8'h04; tick();
    check("R2 request raised", {7'b0, int_req}, 8'h01);
    lines = 8'h00; tick();
    check("R2 withdrawn", {7'b0, int_req}, 8'h00);
    do_ack();
    check("R6 spurious vector", vec, 8'h07);
    lines = 8'h80; tick();
    check("R6 line7 still deliverable", {7'b0, int_req}, 8'h01);
    do_ack();
    check("R5 line7 vector", vec, 8'h07);
    cfg(2'd2, 8'h00);
    lines = 8'h00; tick();

    // R7 masked after signalled; pending kept
    lines = 8'h08; tick();
    cfg(2'd0, 8'h08);
    check("R7 masked hides request", {7'b0, int_req}, 8'h00);
    do_ack();
    check("R6 masked-before-ack spurious", vec, 8'h07);
    cfg(2'd0, 8'h00);
    check("R7 unmask re-requests", {7'b0, int_req}, 8'h01);
    do_ack();
    check("R7 delivered line3", vec, 8'h03);
    cfg(2'd2, 8'h00);
    lines = 8'h00; tick();

    // R4/R8 nesting
    lines = 8'h20; tick();
    do_ack();
    check("R5 line5 vector", vec, 8'h05);
    lines = 8'h60; tick();
    check("R4 lower blocked by in-service", {7'b0, int_req}, 8'h00);
    lines = 8'h62; tick();
    check("R4 higher preempts", {7'b0, int_req}, 8'h01);
    do_ack();
    check("R4 line1 vector", vec, 8'h01);
    cfg(2'd2, 8'h00);
    check("R8 eoi clears line1 only", {7'b0, int_req}, 8'h00);
    cfg(2'd2, 8'h00);
    check("R8 eoi clears line5", {7'b0, int_req}, 8'h01);
    do_ack();
    check("R8 line6 delivered", vec, 8'h06);
    cfg(2'd2, 8'h00);
    lines = 8'h00; tick(); tick();
    finish_run();
  end
endmodule